// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer and Serial Port

This block is the digital side of a 12-bit successive-approximation converter. The comparator is modelled digitally. At the start of a conversion the block holds the sampled input, which arrives as a code. It then builds trial codes internally and resolves the result one bit at a time, from the most significant bit down to the least. The finished word is formatted and copied into output latches.

A host drives three asynchronous lines: a convert-start line, a serial clock and a serial data input. The block sends the latched result back on a serial data output that has a separate enable, so the pad can present it as a three-state pin. While the result shifts out, the host shifts in a 6-bit configuration word. That word selects the input pairing and the output format, and it takes effect at the next conversion.

The level of the convert-start line when a conversion finishes decides the next state. If the line is still high, the block goes to sleep. If it is low, the block stays awake.

Top module: `sar_adc_port`

## Requirements
- R1: A rising edge of the synchronised convert-start line begins a conversion when the block is not converting. Rising edges that arrive during a conversion are ignored, and the conversion in progress keeps the input code it held at its start.
- R2: The register resolves bit 11 down to bit 0. A trial bit is kept when the trial code is not above the held input code. In unipolar format the latched result equals the held input code.
- R3: If the synchronised start line is high in the cycle the conversion ends, `status_o` becomes 2 (sleeping). When the line goes low, `status_o` becomes 0 (awake), and B11 then appears on `sdo_o` with `sdo_oe_o` high.
- R4: If the start line is already low when the conversion ends, `status_o` goes straight to 0 and B11 is on `sdo_o` at once.
- R5: `sdo_oe_o` is 1 only when `status_o` is 0 and the synchronised start line is low. It is 0 while converting, while sleeping, and whenever the start line is high. When `sdo_oe_o` is 0, `sdo_o` is 0.
- R6: Each synchronised falling edge of `sclk_i` while the output is enabled moves `sdo_o` to the next bit, from B11 down to B0. Zeros follow B0.
- R7: `sdi_i` is taken only on the first 6 rising serial-clock edges after a conversion ends. The first bit is the single-ended flag, the second is the odd/sign flag and the fifth is the unipolar flag. The third, fourth and sixth bits, and every later rising edge, have no effect.
- R8: `acq_o` is 0 after reset. It rises after the sixth configuration bit is taken, stays high while the remaining result bits shift out, and clears when the next conversion starts.
- R9: When the unipolar flag is 1, the result is the input code as straight binary. When it is 0, the result is two's complement: the input code with bit 11 inverted (input code 0 is the most negative value).
- R10: A complete configuration word applies from the next conversion start onward. `cfg_o` shows {single, odd, unipolar} for the conversion being converted or read. A frame with fewer than 6 rising edges leaves the pending configuration unchanged.
- R11: After reset, `status_o` is 0, the result latches hold 0, `cfg_o` is 3'b001 and `acq_o` is 0.
- R12: The asynchronous inputs pass through SYNC_STAGES flops. A conversion occupies CONV_CYCLES clock cycles (default 13: one per bit plus a load cycle), so `status_o` leaves 1 exactly CONV_CYCLES+4 cycles after the start pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start_i | input | 1 | Convert-start line, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial configuration input |
| sample_i | input | RES_BITS | Sampled input code fed to the digital comparator |
| sdo_o | output | 1 | Serial result data |
| sdo_oe_o | output | 1 | Drive enable for the three-state data pad |
| acq_o | output | 1 | Acquisition phase for the next conversion |
| status_o | output | 2 | 0 awake, 1 converting, 2 sleeping |
| cfg_o | output | 3 | Active configuration {single, odd, unipolar} |

## Verification
Two things happen in the same cycle at the end of a conversion: the result latches load, and the level of the start line is sampled to choose between sleep and awake. The bench exercises both orders. In one case the start line is released before the end of conversion; in the other it is held high past it. It then checks the status and the B11 presented on the output in each case. A second start edge is also pushed into the busy window while the input code changes. The bench judges this by the moment conversion ends and by the latched result matching the first code. Expected words are computed arithmetically from the input code and the configuration model.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int CFG_WORD_BITS = 6;
    // Positions inside the shifted configuration word (first bit lands at the top)
    localparam int POS_SINGLE = 5;
    localparam int POS_ODD    = 4;
    localparam int POS_UNI    = 1;

    typedef enum logic [1:0] {
        ST_AWAKE = 2'd0,
        ST_CONV  = 2'd1,
        ST_SLEEP = 2'd2
    } stat_e;

    typedef struct packed {
        logic single;
        logic odd;
        logic uni;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{single: 1'b0, odd: 1'b0, uni: 1'b1};

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);
    logic [WIDTH-1:0] pipe_d [STAGES];
    logic [WIDTH-1:0] pipe_q [STAGES];

    always_comb begin
        pipe_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= pipe_d[i];
        end
    end

    assign level_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
    parameter int BITS        = 12,
    parameter int CONV_CYCLES = BITS + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_i,
    input  logic [BITS-1:0] code_i,
    input  logic            bipolar_i,
    output logic            done_o,
    output logic [BITS-1:0] result_o
);
    localparam int CW = $clog2(CONV_CYCLES + 1);
    localparam logic [CW-1:0]   LAST    = CW'(CONV_CYCLES - 1);
    localparam logic [BITS-1:0] MSB_ONE = {1'b1, {(BITS-1){1'b0}}};

    typedef struct packed {
        logic            busy;
        logic [CW-1:0]   cnt;
        logic [BITS-1:0] held;
        logic [BITS-1:0] sar;
        logic [BITS-1:0] result;
        logic            bip;
        logic            done;
    } eng_t;

    eng_t q, n;
    logic [BITS-1:0] weight;
    logic [BITS-1:0] trial;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        weight = MSB_ONE >> q.cnt;   // zero once every bit is resolved
        trial  = q.sar | weight;
        if (!q.busy) begin
            if (go_i) begin
                n.busy = 1'b1;
                n.cnt  = '0;
                n.held = code_i;
                n.sar  = '0;
                n.bip  = bipolar_i;
            end
        end else begin
            if (weight != '0 && trial <= q.held) n.sar = trial;
            if (q.cnt == LAST) begin
                n.busy   = 1'b0;
                n.done   = 1'b1;
                n.result = q.bip ? (q.sar ^ MSB_ONE) : q.sar;
            end else begin
                n.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign done_o   = q.done;
    assign result_o = q.result;

    // R2: the resolved word reproduces the held input code
    a_r2_unipolar_exact: assert property (@(posedge clk) disable iff (!rst_n)
        q.done && !q.bip |-> q.result == q.held);
    a_r9_bipolar_offset: assert property (@(posedge clk) disable iff (!rst_n)
        q.done && q.bip |-> q.result == (q.held ^ MSB_ONE));
    // R12: a conversion ends only after its last counted cycle
    a_r12_length: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> $past(q.busy) && $past(q.cnt) == LAST);
endmodule

// File: rtl/sar_serial.sv
module sar_serial
    import sar_pkg::*;
#(
    parameter int BITS = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [BITS-1:0] result_i,
    input  logic            clear_acq_i,
    input  logic            active_i,
    input  logic            sclk_rise_i,
    input  logic            sclk_fall_i,
    input  logic            sdi_i,
    output logic            data_o,
    output logic            acq_o,
    output cfg_t            pend_o
);
    localparam int RW = $clog2(CFG_WORD_BITS + 1);
    localparam logic [RW-1:0] FULL = RW'(CFG_WORD_BITS);

    typedef struct packed {
        logic [BITS-1:0]          shreg;
        logic [RW-1:0]            rcnt;
        logic [CFG_WORD_BITS-1:0] word;
        cfg_t                     pend;
        logic                     acq;
    } ser_t;

    ser_t q, n;
    logic [CFG_WORD_BITS-1:0] word_next;

    always_comb begin
        n         = q;
        word_next = {q.word[CFG_WORD_BITS-2:0], sdi_i};
        if (load_i) begin
            n.shreg = result_i;
            n.rcnt  = '0;
            n.acq   = 1'b0;
        end else begin
            if (clear_acq_i) n.acq = 1'b0;
            if (active_i) begin
                if (sclk_fall_i) n.shreg = {q.shreg[BITS-2:0], 1'b0};
                if (sclk_rise_i && q.rcnt < FULL) begin
                    n.word = word_next;
                    n.rcnt = q.rcnt + 1'b1;
                    if (q.rcnt == FULL - 1'b1) begin
                        n.pend.single = word_next[POS_SINGLE];
                        n.pend.odd    = word_next[POS_ODD];
                        n.pend.uni    = word_next[POS_UNI];
                        n.acq         = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.pend <= CFG_RESET;
        end else begin
            q <= n;
        end
    end

    assign data_o = q.shreg[BITS-1];
    assign acq_o  = q.acq;
    assign pend_o = q.pend;

    // R7: no more than six configuration bits per frame
    a_r7_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        q.rcnt <= FULL);
    // R8: acquisition begins only once the sixth bit is in
    a_r8_acq_after_sixth: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.acq) |-> q.rcnt == FULL);
    // R6: a falling serial edge advances one bit toward B0
    a_r6_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
        active_i && sclk_fall_i && !load_i |=> q.shreg == {$past(q.shreg[BITS-2:0]), 1'b0});
endmodule

// File: rtl/sar_adc_port.sv
module sar_adc_port
    import sar_pkg::*;
#(
    parameter int RES_BITS    = 12,
    parameter int CONV_CYCLES = RES_BITS + 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_start_i,
    input  logic                sclk_i,
    input  logic                sdi_i,
    input  logic [RES_BITS-1:0] sample_i,
    output logic                sdo_o,
    output logic                sdo_oe_o,
    output logic                acq_o,
    output logic [1:0]          status_o,
    output logic [2:0]          cfg_o
);
    typedef struct packed {
        stat_e state;
        cfg_t  cfg;
        logic  start_prev;
        logic  sclk_prev;
    } top_t;

    top_t q, n;
    logic [2:0]          sync_lvl;
    logic                start_lvl, sclk_lvl, sdi_lvl;
    logic                start_rise, sclk_rise, sclk_fall, go;
    logic                done;
    logic [RES_BITS-1:0] result;
    logic                ser_data, out_en;
    cfg_t                pend;

    sar_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({conv_start_i, sclk_i, sdi_i}),
        .level_o (sync_lvl)
    );
    assign {start_lvl, sclk_lvl, sdi_lvl} = sync_lvl;

    assign start_rise = start_lvl & ~q.start_prev;
    assign sclk_rise  = sclk_lvl & ~q.sclk_prev;
    assign sclk_fall  = ~sclk_lvl & q.sclk_prev;
    assign go         = start_rise && (q.state != ST_CONV);
    assign out_en     = (q.state == ST_AWAKE) && !start_lvl;

    sar_engine #(.BITS(RES_BITS), .CONV_CYCLES(CONV_CYCLES)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go),
        .code_i    (sample_i),
        .bipolar_i (~pend.uni),
        .done_o    (done),
        .result_o  (result)
    );

    sar_serial #(.BITS(RES_BITS)) u_serial (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (done),
        .result_i    (result),
        .clear_acq_i (go),
        .active_i    (out_en),
        .sclk_rise_i (sclk_rise),
        .sclk_fall_i (sclk_fall),
        .sdi_i       (sdi_lvl),
        .data_o      (ser_data),
        .acq_o       (acq_o),
        .pend_o      (pend)
    );

    always_comb begin
        n            = q;
        n.start_prev = start_lvl;
        n.sclk_prev  = sclk_lvl;
        unique case (q.state)
            ST_CONV:  if (done) n.state = start_lvl ? ST_SLEEP : ST_AWAKE;
            ST_SLEEP: if (!start_lvl) n.state = ST_AWAKE;
            default:  ;
        endcase
        if (go) begin
            n.state = ST_CONV;
            n.cfg   = pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_AWAKE;
            q.cfg   <= CFG_RESET;
        end else begin
            q <= n;
        end
    end

    assign sdo_oe_o = out_en;
    assign sdo_o    = out_en & ser_data;
    assign status_o = q.state;
    assign cfg_o    = q.cfg;

    // R1: a conversion runs to its end whatever the start line does
    a_r1_hold_conv: assert property (@(posedge clk) disable iff (!rst_n)
        q.state == ST_CONV && !done |=> q.state == ST_CONV);
    // R3: start still high at the end sends the block to sleep
    a_r3_enter_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        q.state == ST_CONV && done && start_lvl |=> q.state == ST_SLEEP);
    a_r3_wake: assert property (@(posedge clk) disable iff (!rst_n)
        q.state == ST_SLEEP && !start_lvl |=> q.state == ST_AWAKE);
    // R4: start already low at the end keeps the block awake
    a_r4_stay_awake: assert property (@(posedge clk) disable iff (!rst_n)
        q.state == ST_CONV && done && !start_lvl |=> q.state == ST_AWAKE);
    // R5: the pad is never driven during a conversion or in sleep
    a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        q.state != ST_AWAKE |-> !sdo_oe_o && !sdo_o);
    // R10: the active configuration changes only at a conversion start
    a_r10_cfg_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> $stable(q.cfg));
endmodule

// File: tb/tb_sar_adc_port.sv
module tb_sar_adc_port;
    localparam int CLK_PERIOD = 10;
    localparam int RES        = 12;
    localparam int CONV_CYC   = RES + 1;
    localparam int HALF_SCLK  = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic conv_start = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic [RES-1:0] sample = '0;
    logic sdo, oe, acq;
    logic [1:0] status;
    logic [2:0] cfg;

    sar_adc_port dut (
        .clk(clk), .rst_n(rst_n), .conv_start_i(conv_start), .sclk_i(sclk),
        .sdi_i(sdi), .sample_i(sample), .sdo_o(sdo), .sdo_oe_o(oe),
        .acq_o(acq), .status_o(status), .cfg_o(cfg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int  n_cmp = 0, n_bad = 0;
    bit  finished = 1'b0;
    logic [2:0] pend_m = 3'b001;
    logic [2:0] act_m  = 3'b001;

    task automatic chk(input bit ok, input string req, input int actual, input int expected);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    function automatic logic [RES-1:0] expect_code(input logic [RES-1:0] s, input logic [2:0] c);
        return c[0] ? s : (s ^ 12'h800);
    endfunction

    task automatic convert(input logic [RES-1:0] s, input bit sleep);
        logic [RES-1:0] e;
        sample     = s;
        act_m      = pend_m;
        e          = expect_code(s, act_m);
        conv_start = 1'b1;
        step(4);
        chk(status == 2'd1, "R1 converting after start edge", status, 1);
        chk(oe == 1'b0, "R5 output off while start high", oe, 0);
        if (!sleep) conv_start = 1'b0;
        step(16);
        if (sleep) begin
            chk(status == 2'd2, "R3 sleep when start high at end", status, 2);
            chk(oe == 1'b0, "R5 output off in sleep", oe, 0);
            conv_start = 1'b0;
            step(4);
            chk(status == 2'd0, "R3 wake on start low", status, 0);
        end else begin
            chk(status == 2'd0, "R4 awake when start low at end", status, 0);
        end
        chk(oe == 1'b1, "R5 output enabled when awake and low", oe, 1);
        chk(sdo == e[RES-1], "R3/R4 B11 presented", sdo, e[RES-1]);
        chk(acq == 1'b0, "R8 cleared at conversion start", acq, 0);
        chk(cfg == act_m, "R10 active config (R7 ignores other bits)", cfg, act_m);
    endtask

    task automatic frame(input logic [5:0] w, input int pulses, output logic [RES-1:0] got);
        got = '0;
        for (int i = 0; i < pulses; i++) begin
            got[RES-1-i] = sdo;
            sdi  = (i < 6) ? w[5-i] : ~w[i-6];
            sclk = 1'b1;
            step(HALF_SCLK);
            if (i == 4) chk(acq == 1'b0, "R8 no acquisition before sixth bit", acq, 0);
            if (i == 5) chk(acq == 1'b1, "R8 acquisition after sixth bit", acq, 1);
            sclk = 1'b0;
            step(HALF_SCLK);
        end
        if (pulses >= 6) pend_m = {w[5], w[4], w[1]};
        chk(cfg == act_m, "R10 new config not applied mid-frame", cfg, act_m);
        if (pulses == RES) chk(sdo == 1'b0, "R6 zeros after B0", sdo, 0);
    endtask

    function automatic logic [RES-1:0] code_of(input int k);
        case (k)
            0: return 12'h000;
            1: return 12'hFFF;
            2: return 12'h800;
            3: return 12'h7FF;
            4: return 12'h001;
            5: return 12'hFFE;
            default: return 12'((k * 53 + (k >> 1) * 977) % 4096);
        endcase
    endfunction

    initial begin
        logic [RES-1:0] got, e;
        step(3);
        rst_n = 1'b1;
        step(4);
        chk(status == 2'd0, "R11 reset status awake", status, 0);
        chk(cfg == 3'b001, "R11 reset config", cfg, 1);
        chk(acq == 1'b0, "R11 reset acquisition low", acq, 0);
        chk(sdo == 1'b0, "R11 reset result latches zero", sdo, 0);
        chk(oe == 1'b1, "R5 enabled with start low after reset", oe, 1);

        // R12: exact conversion length
        sample = 12'h5A3; act_m = pend_m;
        conv_start = 1'b1;
        step(4);
        conv_start = 1'b0;
        step(CONV_CYC + 3 - 4);
        chk(status == 2'd1, "R12 still converting at CONV+3", status, 1);
        step(1);
        chk(status == 2'd0, "R12 finished at CONV+4", status, 0);
        frame(6'b000000, RES, got);
        e = expect_code(12'h5A3, act_m);
        chk(got == e, "R2 unipolar result", got, e);

        // R1: second edge and input change during a conversion are ignored
        act_m = pend_m;
        sample = 12'h3C5;
        conv_start = 1'b1;
        step(4); conv_start = 1'b0;
        step(1); sample = 12'hA5A;
        step(3); conv_start = 1'b1;
        step(4); conv_start = 1'b0;
        step(5);
        chk(status == 2'd0, "R1 second edge did not restart", status, 0);
        e = expect_code(12'h3C5, act_m);
        chk(sdo == e[RES-1], "R1 B11 from first sample", sdo, e[RES-1]);
        frame(6'b100010, RES, got);
        chk(got == e, "R1 R9 bipolar result from held sample", got, e);

        // Sweep over codes, formats, sleep and awake endings
        for (int k = 0; k < 80; k++) begin
            logic [RES-1:0] s;
            logic [5:0]     w;
            int             pulses;
            s = code_of(k);
            convert(s, (k % 3) == 1);
            w = {k[1], k[2], k[3], ~k[0], k[0] ^ k[2], k[4]};
            pulses = ((k % 9) == 8) ? 5 : RES;
            frame(w, pulses, got);
            e = expect_code(s, act_m);
            if (pulses == RES)
                chk(got == e, "R2 R6 R9 shifted result", got, e);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule